// File: doc/BRIEF.md
# Configuration Status Register for a Bus Target/Master Device

This block is the 16-bit status word of a PCI-style configuration header. It catches error and abort events that the surrounding bus interface reports as single-cycle strobes and holds each one in a sticky bit. Software reads the word to see what happened. It clears a bit by writing 1 to that bit position while the matching byte lane is enabled.

The remaining bits are not writable. Two capability flags mirror static configuration straps: fast back-to-back support and presence of a capability list. The device-select timing field always reports medium timing, meaning select is asserted two clocks after the frame starts. All other bits read as zero.

The data-parity sticky bit is different from the other sticky bits. It is set only when three conditions hold in the same cycle: a parity-error signal was driven or sensed, the device was mastering the transfer, and the parity-response enable from the command word is on. Bus protocol decoding and parity generation belong to other blocks.

Top module: `cfgstat_reg`

## Requirements
- R1: Bit 15 (parity detected) becomes 1 one clock after `evParityDet` is high, whatever the value of `parityRespEn`.
- R2: Bits 14, 13, 12 and 11 become 1 one clock after `evSysErr`, `evMasterAbort`, `evTargetAbortRcvd` and `evTargetAbortSig` are high, respectively. Each strobe affects only its own bit.
- R3: A write with `wrEn` high, `wrByteEn[1]` high and `wrData[k]` = 1 clears sticky bit k one clock later, for any k in {15,14,13,12,11,8}. If `wrByteEn[1]` is low, no sticky bit changes. A 0 written to a sticky bit leaves it unchanged.
- R4: If a sticky bit's event and a clearing write for that bit occur in the same cycle, the bit reads 1 afterwards.
- R5: Bits 10:9 always read as 2'b01.
- R6: Bit 8 becomes 1 one clock after `perrActive`, `busMaster` and `parityRespEn` are all high together. It does not change when any one of the three is low.
- R7: Bit 7 always reads as `strapFastB2B`. Writes have no effect on it.
- R8: Bit 4 always reads as `strapPmEnable`. Writes have no effect on it.
- R9: Bits 6, 5 and 3:0 always read as 0. Writes to them, on either byte lane, have no effect.
- R10: While synchronous reset `rst` is high at a clock edge, all six sticky bits are cleared to 0 by that edge.
- R11: A sticky bit that is neither set by its event nor cleared by a write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evParityDet | input | 1 | Strobe: parity error detected |
| evSysErr | input | 1 | Strobe: system error asserted by this device |
| evMasterAbort | input | 1 | Strobe: own master transaction ended in master abort |
| evTargetAbortRcvd | input | 1 | Strobe: own master transaction ended by target abort |
| evTargetAbortSig | input | 1 | Strobe: this device ended a transaction with target abort |
| perrActive | input | 1 | Parity-error signal driven or sensed this cycle |
| busMaster | input | 1 | Device is master of the transfer in question |
| parityRespEn | input | 1 | Parity-response enable from the command word |
| strapFastB2B | input | 1 | Strap: fast back-to-back capable |
| strapPmEnable | input | 1 | Strap: power management / capability list present |
| wrEn | input | 1 | Configuration write to this register |
| wrByteEn | input | 2 | Byte lane enables; bit 1 covers bits 15:8, bit 0 covers bits 7:0 |
| wrData | input | 16 | Write data |
| statusOut | output | 16 | Register read value |

## Verification
The checker assumes that every event input and every write-port input is a known value at each rising edge. It also assumes that the straps stay constant while reset is low, so that a strap bit is compared with the strap value in the same cycle. The bench changes all inputs only on the falling edge. It changes the straps only between scenarios and does so away from any rising edge. Every strobe is held for exactly one cycle, so each set and clear step can be matched to one rising edge.

// File: rtl/cfgstat_pkg.sv
package cfgstat_pkg;

  localparam int REG_W    = 16;
  localparam int LANE_W   = 8;
  localparam int LANES    = REG_W / LANE_W;
  localparam int STICKY_N = 6;

  // sticky slot index -> bit position in the register
  localparam int SLOT_DATAPAR  = 0;
  localparam int SLOT_TABTSIG  = 1;
  localparam int SLOT_TABTRCV  = 2;
  localparam int SLOT_MABT     = 3;
  localparam int SLOT_SYSERR   = 4;
  localparam int SLOT_PARDET   = 5;

  localparam int POS_DEVSEL_LO = 9;
  localparam int POS_FASTB2B   = 7;
  localparam int POS_NEWCAP    = 4;
  localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;

  typedef struct packed {
    logic [STICKY_N-1:0] setReq;
    logic [STICKY_N-1:0] clrReq;
  } stsStrobe_t;

  function automatic int stickyPos(input int slot);
    case (slot)
      SLOT_DATAPAR: return 8;
      SLOT_TABTSIG: return 11;
      SLOT_TABTRCV: return 12;
      SLOT_MABT:    return 13;
      SLOT_SYSERR:  return 14;
      default:      return 15;
    endcase
  endfunction

endpackage

// File: rtl/cfgstat_ctrl.sv
module cfgstat_ctrl
  import cfgstat_pkg::*;
(
  input  logic              evParityDet,
  input  logic              evSysErr,
  input  logic              evMasterAbort,
  input  logic              evTargetAbortRcvd,
  input  logic              evTargetAbortSig,
  input  logic              perrActive,
  input  logic              busMaster,
  input  logic              parityRespEn,
  input  logic              wrEn,
  input  logic [LANES-1:0]  wrByteEn,
  input  logic [REG_W-1:0]  wrData,
  output stsStrobe_t        strobes
);

  logic [STICKY_N-1:0] eventVec;
  logic                unusedWrBits;

  // data-parity qualifies on all three conditions; parity-detect has no enable
  always_comb begin
    eventVec               = '0;
    eventVec[SLOT_DATAPAR] = perrActive & busMaster & parityRespEn;
    eventVec[SLOT_TABTSIG] = evTargetAbortSig;
    eventVec[SLOT_TABTRCV] = evTargetAbortRcvd;
    eventVec[SLOT_MABT]    = evMasterAbort;
    eventVec[SLOT_SYSERR]  = evSysErr;
    eventVec[SLOT_PARDET]  = evParityDet;
  end

  assign strobes.setReq = eventVec;

  generate
    for (genvar s = 0; s < STICKY_N; s++) begin : g_clr
      localparam int BIT_POS  = stickyPos(s);
      localparam int LANE_IDX = BIT_POS / LANE_W;
      assign strobes.clrReq[s] = wrEn & wrByteEn[LANE_IDX] & wrData[BIT_POS];
    end
  endgenerate

  // only the sticky positions of the write data matter
  assign unusedWrBits = ^wrData;

endmodule

// File: rtl/cfgstat_dp.sv
module cfgstat_dp
  import cfgstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stsStrobe_t        strobes,
  input  logic              strapFastB2B,
  input  logic              strapPmEnable,
  output logic [REG_W-1:0]  readValue
);

  logic [STICKY_N-1:0] stickyQ;

  generate
    for (genvar s = 0; s < STICKY_N; s++) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)                     stickyQ[s] <= 1'b0;
        else if (strobes.setReq[s])  stickyQ[s] <= 1'b1;   // set beats clear
        else if (strobes.clrReq[s])  stickyQ[s] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    readValue = '0;
    for (int s = 0; s < STICKY_N; s++) begin
      readValue[stickyPos(s)] = stickyQ[s];
    end
    readValue[POS_DEVSEL_LO +: 2] = DEVSEL_MEDIUM;
    readValue[POS_FASTB2B]        = strapFastB2B;
    readValue[POS_NEWCAP]         = strapPmEnable;
  end

endmodule

// File: rtl/cfgstat_reg.sv
module cfgstat_reg
  import cfgstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evParityDet,
  input  logic              evSysErr,
  input  logic              evMasterAbort,
  input  logic              evTargetAbortRcvd,
  input  logic              evTargetAbortSig,
  input  logic              perrActive,
  input  logic              busMaster,
  input  logic              parityRespEn,
  input  logic              strapFastB2B,
  input  logic              strapPmEnable,
  input  logic              wrEn,
  input  logic [1:0]        wrByteEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       statusOut
);

  stsStrobe_t strobes;

  cfgstat_ctrl u_ctrl (
    .evParityDet       (evParityDet),
    .evSysErr          (evSysErr),
    .evMasterAbort     (evMasterAbort),
    .evTargetAbortRcvd (evTargetAbortRcvd),
    .evTargetAbortSig  (evTargetAbortSig),
    .perrActive        (perrActive),
    .busMaster         (busMaster),
    .parityRespEn      (parityRespEn),
    .wrEn              (wrEn),
    .wrByteEn          (wrByteEn),
    .wrData            (wrData),
    .strobes           (strobes)
  );

  cfgstat_dp u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .strapFastB2B  (strapFastB2B),
    .strapPmEnable (strapPmEnable),
    .readValue     (statusOut)
  );

endmodule

// File: rtl/cfgstat_chk.sv
module cfgstat_chk (
  input logic        clk,
  input logic        rst,
  input logic        evParityDet,
  input logic        evSysErr,
  input logic        evMasterAbort,
  input logic        evTargetAbortRcvd,
  input logic        evTargetAbortSig,
  input logic        perrActive,
  input logic        busMaster,
  input logic        parityRespEn,
  input logic        strapFastB2B,
  input logic        strapPmEnable,
  input logic        wrEn,
  input logic [1:0]  wrByteEn,
  input logic [15:0] wrData,
  input logic [15:0] statusOut
);

  logic hiClr;
  logic dpCond;
  assign hiClr  = wrEn & wrByteEn[1];
  assign dpCond = perrActive & busMaster & parityRespEn;

  assert_pardet_R1: assert property (@(posedge clk) disable iff (rst)
    evParityDet |=> statusOut[15]);

  assert_syserr_R2: assert property (@(posedge clk) disable iff (rst)
    evSysErr |=> statusOut[14]);

  assert_mabt_R2: assert property (@(posedge clk) disable iff (rst)
    evMasterAbort |=> statusOut[13]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (hiClr && wrData[13] && !evMasterAbort) |=> !statusOut[13]);

  assert_setwins_R4: assert property (@(posedge clk) disable iff (rst)
    (hiClr && wrData[12] && evTargetAbortRcvd) |=> statusOut[12]);

  assert_devsel_R5: assert property (@(posedge clk) disable iff (rst)
    statusOut[10:9] == 2'b01);

  assert_datapar_R6: assert property (@(posedge clk) disable iff (rst)
    dpCond |=> statusOut[8]);

  assert_datapar_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!dpCond && !(hiClr && wrData[8])) |=> $stable(statusOut[8]));

  assert_fastb2b_R7: assert property (@(posedge clk) disable iff (rst)
    statusOut[7] == strapFastB2B);

  assert_newcap_R8: assert property (@(posedge clk) disable iff (rst)
    statusOut[4] == strapPmEnable);

  assert_zeros_R9: assert property (@(posedge clk) disable iff (rst)
    statusOut[6:5] == 2'b00 && statusOut[3:0] == 4'h0);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (statusOut & 16'hF900) == 16'h0000);

  assert_tabtsig_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!evTargetAbortSig && !(hiClr && wrData[11])) |=> $stable(statusOut[11]));

endmodule

bind cfgstat_reg cfgstat_chk u_chk (.*);

// File: tb/tb_cfgstat_reg.sv
`timescale 1ns/1ps
module tb_cfgstat_reg;

  localparam logic [15:0] STICKY_MASK = 16'hF900;

  logic        clk = 1'b0;
  logic        rst;
  logic        evParityDet, evSysErr, evMasterAbort, evTargetAbortRcvd, evTargetAbortSig;
  logic        perrActive, busMaster, parityRespEn;
  logic        strapFastB2B, strapPmEnable;
  logic        wrEn;
  logic [1:0]  wrByteEn;
  logic [15:0] wrData;
  logic [15:0] statusOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [15:0] expSticky;

  always #4 clk = ~clk;

  cfgstat_reg dut (.*);

  function automatic logic [15:0] expRead();
    logic [15:0] v;
    v = expSticky & STICKY_MASK;
    v[10:9] = 2'b01;
    v[7] = strapFastB2B;
    v[4] = strapPmEnable;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: statusOut actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    evParityDet = 0; evSysErr = 0; evMasterAbort = 0;
    evTargetAbortRcvd = 0; evTargetAbortSig = 0;
    perrActive = 0; busMaster = 0; parityRespEn = 0;
    wrEn = 0; wrByteEn = 2'b00; wrData = 16'h0000;
  endtask

  // ev = {parDet, sysErr, mAbt, tAbtRcv, tAbtSig}; dp = {perr, master, respEn}
  task automatic cycle(input string req, input logic [4:0] ev, input logic [2:0] dp,
                       input logic we, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] setM, clrM, laneM;
    @(negedge clk);
    {evParityDet, evSysErr, evMasterAbort, evTargetAbortRcvd, evTargetAbortSig} = ev;
    {perrActive, busMaster, parityRespEn} = dp;
    wrEn = we; wrByteEn = be; wrData = d;
    setM = {ev, 2'b00, (&dp), 8'h00};
    laneM = {{8{be[1]}}, {8{be[0]}}};
    clrM = we ? (d & laneM & STICKY_MASK) : 16'h0000;
    expSticky = (expSticky & ~clrM) | setM;
    @(negedge clk);
    idleInputs();
    check(req, statusOut, expRead());
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1;
    {evParityDet, evSysErr, evMasterAbort, evTargetAbortRcvd, evTargetAbortSig} = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    rst = 0; idleInputs();
    expSticky = 16'h0000;
    check("R10 reset", statusOut, expRead());
  endtask

  task automatic t_events();
    cycle("R1 parity detect, enable off", 5'b10000, 3'b000, 0, 2'b00, 0);
    cycle("R2 system error", 5'b01000, 3'b000, 0, 2'b00, 0);
    cycle("R2 master abort", 5'b00100, 3'b000, 0, 2'b00, 0);
    cycle("R2 target abort received", 5'b00010, 3'b000, 0, 2'b00, 0);
    cycle("R2 target abort signaled", 5'b00001, 3'b000, 0, 2'b00, 0);
    cycle("R11 idle holds", 5'b00000, 3'b000, 0, 2'b00, 0);
  endtask

  task automatic t_dataParity();
    for (int k = 0; k < 7; k++) begin
      cycle("R6 partial condition", 5'b00000, 3'(k), 0, 2'b00, 0);
    end
    check("R6 bit8 still clear", statusOut & 16'h0100, 16'h0000);
    cycle("R6 all three conditions", 5'b00000, 3'b111, 0, 2'b00, 0);
    check("R6 bit8 set", statusOut & 16'h0100, 16'h0100);
  endtask

  task automatic t_clear();
    cycle("R3 low lane only ignored", 0, 0, 1, 2'b01, 16'hFFFF);
    cycle("R3 no lanes ignored", 0, 0, 1, 2'b00, 16'hFFFF);
    cycle("R3 zeros do not clear", 0, 0, 1, 2'b11, 16'h0000);
    cycle("R3 clear bit 13 only", 0, 0, 1, 2'b10, 16'h2000);
    cycle("R3 clear bits 15 and 8", 0, 0, 1, 2'b10, 16'h8100);
    cycle("R3 clear all", 0, 0, 1, 2'b11, 16'hFFFF);
    check("R3 sticky all zero", statusOut & STICKY_MASK, 16'h0000);
  endtask

  task automatic t_collide();
    cycle("R4 set wins over clear", 5'b01010, 3'b111, 1, 2'b10, 16'hFFFF);
    check("R4 bits 14,12,8 remain", statusOut & STICKY_MASK, 16'h5100);
    cycle("R4 follow-up clear", 0, 0, 1, 2'b10, 16'hFFFF);
  endtask

  task automatic t_straps();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      {strapFastB2B, strapPmEnable} = 2'(k);
      cycle("R7 R8 strap bits under write", 0, 0, 1, 2'b11, 16'h06FF);
      cycle("R9 R5 write zeros", 0, 0, 1, 2'b11, 16'h0000);
    end
    check("R5 R9 fixed field value", statusOut & 16'h066F, 16'h0200);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    idleInputs();
    strapFastB2B = 0; strapPmEnable = 0;
    expSticky = 16'h0000;
    rst = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_events();
    t_dataParity();
    t_clear();
    t_collide();
    t_straps();
    t_events();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule